// File: doc/BRIEF.md
# Clock-Independent Sticky Level Event Bank

This block watches a group of external input pins and records each one's active level in a sticky flag per channel. Its main use is to catch power-down warnings and similar signals that can arrive while the bus clock is gated off. Each flag is set asynchronously by the pin's level after the per-channel polarity is applied. A flag therefore records an event even when no clock edge occurs. Once set, the flag holds until software clears it with a write-one-to-clear access on the bus clock.

Software controls and reads the bank through a 32-bit register interface on the bus clock. Through it, software sets the per-channel enable and polarity, reads the raw and masked flags, and clears flags. The raw flags pass through a two-flop synchroniser before they reach the read path. The single interrupt output is taken straight from the asynchronous flags gated by the enables, so it can wake the system with the clock stopped. The live pin levels cannot be read.

Register offsets, byte addressed, with channel i at bit i:

| Offset | Access | Function |
|---|---|---|
| 0x00 | read/write | enable |
| 0x04 | read-only | raw flags (synchronised) |
| 0x08 | read-only | masked flags |
| 0x0C | write-1-to-clear | clear, reads 0 |
| 0x10 | read/write | polarity, 0 = active-high, 1 = active-low |
| 0x14 | read/write | mode, storage only |

Top module: `lvl_latch_bank`

## Requirements
- R1: After reset, every register reads 0 and irq_out is 0.
- R2: An active level on channel i sets bit i of the raw register at 0x04, even if the level is held for less than a clock period. The bit stays set after the input returns inactive.
- R3: Polarity bit i at 0x10 selects the active level of channel i: 0 means a high level is active and 1 means a low level is active.
- R4: Writing 1 to bit i at 0x0C clears flag i. Writing 0 to a bit leaves that flag unchanged. Offset 0x0C always reads 0.
- R5: The masked register at 0x08 reads raw AND enable, where enable is at 0x00. irq_out is high exactly when some enabled flag is set.
- R6: While channel i's level is still active, a clear write to bit i has no effect and the flag stays set.
- R7: An active level that occurs while clk is stopped raises irq_out without any clock edge, if the channel is enabled. The event appears in the raw register once the clock runs again.
- R8: The mode register at 0x14 stores and returns its low 8 bits and has no effect on capture.
- R9: Register bits above the channel count read 0, and offsets 0x18 and 0x1C read 0.
- R10: A flag set between two rising clock edges appears in the raw register only after the second of those edges, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, may be stopped |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge of clk |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_in | input | 8 | External event inputs, asynchronous to clk |
| irq_out | output | 1 | Combined interrupt, high when an enabled flag is set |

## Verification
A clear write and a still-active level can act on the same flag in the same clock cycle. The bench holds one input active and writes its clear bit. It then expects the raw bit, the masked bit and irq_out all to stay set. It expects the bit to clear only after the input is released and cleared again. A second overlap is a capture that lands between two edges while the synchroniser is moving. The bench pulses an input just after a clock edge and expects the raw bit to read 0 after the next edge and 1 after the edge that follows it.

// File: rtl/lvl_latch_pkg.sv
package lvl_latch_pkg;
   localparam int BUS_W  = 32;
   localparam int ADDR_W = 5;

   typedef enum logic [ADDR_W-1:0] {
      OFS_ENABLE = 5'h00,
      OFS_RAW    = 5'h04,
      OFS_MASKED = 5'h08,
      OFS_CLEAR  = 5'h0C,
      OFS_POLAR  = 5'h10,
      OFS_MODE   = 5'h14
   } reg_ofs_e;
endpackage

// File: rtl/lvl_latch_cell.sv
module lvl_latch_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic pol_low,
   input  logic clr,
   output logic flag
);
   logic act;
   assign act = pin ^ pol_low;

   // Set on the active level with no clock needed; the level wins over a clear.
   always_ff @(posedge clk or negedge rst_n or posedge act) begin
      if (!rst_n)   flag <= 1'b0;
      else if (act) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      act |=> flag)
      else $error("active level did not leave flag set");
endmodule

// File: rtl/lvl_sync.sv
module lvl_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("lvl_sync needs at least two stages");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      chain[s] <= '0;
         else if (s == 0) chain[s] <= d;
         else             chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[LAST];

   if (STAGES == 2) begin : g_lag_check
      p_raw_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
         ((q & ~$past(q)) & ~$past(d, 2)) == '0)
         else $error("synchronised bit rose without a source two edges back");
   end
endmodule

// File: rtl/lvl_latch_regs.sv
module lvl_latch_regs
   import lvl_latch_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic [NUM_CH-1:0] raw_sync,
   output logic [NUM_CH-1:0] en_q,
   output logic [NUM_CH-1:0] pol_q,
   output logic [NUM_CH-1:0] clr_vec,
   output logic [BUS_W-1:0]  rdata
);
   localparam int PAD = BUS_W - NUM_CH;

   logic [NUM_CH-1:0] mode_q;
   logic [NUM_CH-1:0] sel_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         pol_q  <= '0;
         mode_q <= '0;
      end else if (wr) begin
         if (addr == OFS_ENABLE) en_q   <= wdata[NUM_CH-1:0];
         if (addr == OFS_POLAR)  pol_q  <= wdata[NUM_CH-1:0];
         if (addr == OFS_MODE)   mode_q <= wdata[NUM_CH-1:0];
      end
   end

   assign clr_vec = (wr && addr == OFS_CLEAR) ? wdata[NUM_CH-1:0] : '0;

   always_comb begin
      case (addr)
         OFS_ENABLE: sel_data = en_q;
         OFS_RAW:    sel_data = raw_sync;
         OFS_MASKED: sel_data = raw_sync & en_q;
         OFS_POLAR:  sel_data = pol_q;
         OFS_MODE:   sel_data = mode_q;
         default:    sel_data = '0;
      endcase
   end

   if (PAD > 0) begin : g_pad
      assign rdata = {{PAD{1'b0}}, sel_data};
   end else begin : g_nopad
      assign rdata = sel_data;
   end

   p_pol_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == OFS_POLAR) |=> pol_q == $past(wdata[NUM_CH-1:0]))
      else $error("polarity write not stored");

   p_clear_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == OFS_CLEAR) |-> rdata == '0)
      else $error("clear register returned data");
endmodule

// File: rtl/lvl_latch_bank.sv
module lvl_latch_bank
   import lvl_latch_pkg::*;
#(
   parameter int NUM_CH      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [NUM_CH-1:0] evt_in,
   output logic              irq_out
);
   if (NUM_CH < 1 || NUM_CH > BUS_W) begin : g_bad_ch
      $error("NUM_CH must be between 1 and the bus width");
   end

   logic [NUM_CH-1:0] flag_vec;
   logic [NUM_CH-1:0] raw_sync;
   logic [NUM_CH-1:0] en_q;
   logic [NUM_CH-1:0] pol_q;
   logic [NUM_CH-1:0] clr_vec;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      lvl_latch_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin     (evt_in[i]),
         .pol_low (pol_q[i]),
         .clr     (clr_vec[i]),
         .flag    (flag_vec[i])
      );
   end

   lvl_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (flag_vec),
      .q     (raw_sync)
   );

   lvl_latch_regs #(.NUM_CH(NUM_CH)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (bus_wr),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .raw_sync (raw_sync),
      .en_q     (en_q),
      .pol_q    (pol_q),
      .clr_vec  (clr_vec),
      .rdata    (bus_rdata)
   );

   // Taken from the asynchronous flags so it can wake a stopped clock.
   assign irq_out = |(flag_vec & en_q);

   p_irq_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (en_q != '0))
      else $error("interrupt with every channel disabled");

   p_masked_within_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == OFS_MASKED) |-> ((bus_rdata[NUM_CH-1:0] & ~en_q) == '0))
      else $error("masked status shows a disabled channel");
endmodule

// File: tb/lvl_latch_bank_tb_top.sv
`timescale 1ns/100ps
module lvl_latch_bank_tb_top;
   logic        clk = 1'b0;
   logic        clk_run = 1'b1;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  evt_in = '0;
   logic        irq_out;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 0;
   bit mon_valid = 0;

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t exp_q[$];

   lvl_latch_bank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
      .irq_out(irq_out)
   );

   // 250 MHz; gating stops the clock while it is low
   always begin
      #2;
      if (clk_run) clk = ~clk;
   end

   // Monitor: pops one expected item per sampled cycle and compares
   always @(negedge clk) begin
      if (mon_valid && exp_q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = exp_q.pop_front();
         act = it.is_irq ? {31'b0, irq_out} : bus_rdata;
         n_checks++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic expect_reg(input logic [4:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(posedge clk); #1;
      bus_addr = a;
      it.is_irq = 0; it.exp = e; it.tag = tag;
      exp_q.push_back(it);
      mon_valid = 1;
      @(negedge clk); #1;
      mon_valid = 0;
   endtask

   task automatic expect_irq(input bit e, input string tag);
      item_t it;
      @(posedge clk); #1;
      it.is_irq = 1; it.exp = {31'b0, e}; it.tag = tag;
      exp_q.push_back(it);
      mon_valid = 1;
      @(negedge clk); #1;
      mon_valid = 0;
   endtask

   task automatic check_now(input logic [31:0] act, input logic [31:0] e, input string tag);
      n_checks++;
      if (act !== e) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, e);
      end
   endtask

   task automatic write_reg(input logic [4:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 0;
   endtask

   task automatic pulse(input int ch);
      @(posedge clk); #1;
      evt_in[ch] = 1'b1;
      #0.5;
      evt_in[ch] = 1'b0;
   endtask

   task automatic settle();
      repeat (3) @(posedge clk);
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset values
      expect_reg(5'h00, 32'h0, "R1 enable");
      expect_reg(5'h04, 32'h0, "R1 raw");
      expect_reg(5'h10, 32'h0, "R1 polarity");
      expect_reg(5'h14, 32'h0, "R1 mode");
      expect_irq(1'b0, "R1 irq");

      // R2 short pulse is captured and held; R5 masked and irq
      write_reg(5'h00, 32'hFFFF_FFFF);
      expect_reg(5'h00, 32'h0000_00FF, "R9 enable upper bits");
      pulse(3);
      settle();
      expect_reg(5'h04, 32'h08, "R2 sticky raw");
      expect_reg(5'h08, 32'h08, "R5 masked");
      expect_irq(1'b1, "R5 irq set");

      // R4 write-one-to-clear, zeros ignored
      write_reg(5'h0C, 32'h0000_0000);
      settle();
      expect_reg(5'h04, 32'h08, "R4 zero write keeps");
      write_reg(5'h0C, 32'h0000_0008);
      settle();
      expect_reg(5'h04, 32'h0, "R4 cleared");
      expect_reg(5'h0C, 32'h0, "R4 clear reads zero");
      expect_irq(1'b0, "R4 irq dropped");

      // R6 clear while the level is active: set wins
      @(posedge clk); #1 evt_in[5] = 1'b1;
      write_reg(5'h0C, 32'h20);
      settle();
      expect_reg(5'h04, 32'h20, "R6 set wins");
      expect_irq(1'b1, "R6 irq held");
      @(posedge clk); #1 evt_in[5] = 1'b0;
      write_reg(5'h0C, 32'h20);
      settle();
      expect_reg(5'h04, 32'h0, "R6 clear after release");

      // R3 active-low polarity captures a low pin
      write_reg(5'h10, 32'h01);
      settle();
      expect_reg(5'h04, 32'h01, "R3 active low");
      expect_reg(5'h10, 32'h01, "R3 polarity readback");
      write_reg(5'h10, 32'h00);
      write_reg(5'h0C, 32'h01);
      settle();
      expect_reg(5'h04, 32'h0, "R3 high polarity idle");

      // R5 disabled channel: raw set, masked and irq clear
      write_reg(5'h00, 32'h0F);
      pulse(6);
      settle();
      expect_reg(5'h04, 32'h40, "R5 raw disabled ch");
      expect_reg(5'h08, 32'h00, "R5 masked disabled ch");
      expect_irq(1'b0, "R5 irq disabled ch");
      write_reg(5'h00, 32'hFF);
      expect_irq(1'b1, "R5 irq after enable");
      expect_reg(5'h08, 32'h40, "R5 masked after enable");
      write_reg(5'h0C, 32'h40);
      settle();

      // R7 capture with the clock stopped
      @(negedge clk);
      clk_run = 1'b0;
      #10 evt_in[2] = 1'b1;
      #3  evt_in[2] = 1'b0;
      #3  check_now({31'b0, irq_out}, 32'h1, "R7 irq without clock");
      #10 clk_run = 1'b1;
      settle();
      expect_reg(5'h04, 32'h04, "R7 raw after restart");
      write_reg(5'h0C, 32'h04);
      settle();

      // R8 mode is storage only
      write_reg(5'h14, 32'h5A);
      expect_reg(5'h14, 32'h5A, "R8 mode readback");
      pulse(7);
      settle();
      expect_reg(5'h04, 32'h80, "R8 capture unchanged");
      write_reg(5'h0C, 32'h80);
      settle();

      // R9 unmapped offsets
      expect_reg(5'h18, 32'h0, "R9 offset 0x18");
      expect_reg(5'h1C, 32'h0, "R9 offset 0x1C");

      // R10 synchroniser latency
      pulse(4);
      expect_reg(5'h04, 32'h00, "R10 not after first edge");
      expect_reg(5'h04, 32'h10, "R10 after second edge");

      settle();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule